// File: doc/BRIEF.md
# Power-Key Reset and Load-Switch Controller

This controller decides when the load switch of a mobile power-management chip is closed. It drives the switch enable and a complementary enable for the output discharge path. Its four inputs are an active-low power/reset key, a wake line, an off-request line and a delay-select strap. All of them are asynchronous and are synchronized inside the block. Every interval is counted in ticks of a 1 ms timebase enable, and each interval is a parameter.

The role of the key depends on the switch state. With the switch open, a long hold closes it. With the switch closed, a longer hold cuts power for a fixed pulse and then restores it. An off request, meaning a rising edge on the off line that stays high for a qualifying time, starts a turn-off delay. Holding the key low or driving wake high during that delay aborts the turn-off. If the strap is low when the key falls, the long waits are bypassed for factory test. A 3-bit code scales the reset hold time.

Top module: `pwr_key_ctrl`

## Requirements
- R1: After reset deasserts, sw_en_o is 1 and dis_en_o is 0.
- R2: With the switch open and dsel_i high, holding key_ni low for T_ON_TICKS ticks closes the switch. A shorter hold leaves it open.
- R3: After any key-driven turn-on or key-driven reset, a continued key hold never starts a reset. key_ni must return high first.
- R4: With the switch closed, the key armed and dsel_i high, holding key_ni low for the scaled reset delay opens the switch for T_PULSE_TICKS ticks and then closes it again. A release before the delay leaves the output unchanged.
- R5: The reset delay is T_RST_TICKS times a factor chosen by mult_sel_i: 0→1.0, 1→0.5, 2→0.75, 3→1.25, 4→1.5, 5→1.75, 6→2.0, 7→1.0.
- R6: If dsel_i is low when key_ni falls, the switch closes at once when it was open. When it was closed and armed, the power pulse starts at once and keeps its full T_PULSE_TICKS length.
- R7: With the switch open, wake_i high closes it.
- R8: A rising edge on off_i that stays high for OFF_QUAL_TICKS ticks starts a turn-off delay. The delay is T_OFF_LONG_TICKS with dsel_i high and T_OFF_SHORT_TICKS with dsel_i low, after which the switch opens. A shorter high pulse is ignored.
- R9: During the turn-off delay, key_ni low or wake_i high cancels the turn-off. A new turn-off needs a new rising edge on off_i.
- R10: An off request that qualifies while key_ni is low or wake_i is high is discarded and is not served later.
- R11: dis_en_o is always the inverse of sw_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 ms timebase enable |
| key_ni | input | 1 | Power/reset key, active low, asynchronous |
| wake_i | input | 1 | Wake request, level, asynchronous |
| off_i | input | 1 | Off request, rising edge, asynchronous |
| dsel_i | input | 1 | Delay-select strap; low selects the fast paths |
| mult_sel_i | input | 3 | Reset-delay multiplier code |
| sw_en_o | output | 1 | Load-switch enable |
| dis_en_o | output | 1 | Output-discharge enable |

## Verification
The assertions assume the following about the inputs:
- Each input holds its level for far longer than the two synchronizer cycles.
- The strap is settled before any key edge it is meant to qualify.
- tick_i is a single-cycle pulse spaced several clocks apart.

The stimulus meets these assumptions in four ways. Every level change is separated by whole tick periods or by at least eight clocks. The strap is changed only while the key is high. The tick is produced once every ten clocks. Random key-hold lengths and multiplier codes are drawn from ranges whose expected outcome is known before each check.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_ON, ST_OFF_WAIT, ST_PULSE} pk_state_e;

  // reset-delay factor in quarters of the base delay
  function automatic logic [3:0] mult_quarters(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd7;
      3'd6:    return 4'd8;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/pkc_sync.sv
module pkc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pkc_rst_delay.sv
module pkc_rst_delay #(
  parameter int CW   = 16,
  parameter int BASE = 7500
) (
  input  logic [2:0]    code_i,
  output logic [CW-1:0] dly_o
);
  import pkc_pkg::*;
  logic [3:0] quarters;
  int         prod;

  assign quarters = mult_quarters(code_i);
  assign prod     = (BASE * int'(quarters)) / 4;
  assign dly_o    = CW'(prod);
endmodule

// File: rtl/pkc_fsm.sv
module pkc_fsm
  import pkc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int T_ON        = 2300,
  parameter int T_PULSE     = 400,
  parameter int T_OFF_LONG  = 7300,
  parameter int T_OFF_SHORT = 1,
  parameter int OFF_QUAL    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          key_low_i,
  input  logic          wake_i,
  input  logic          off_i,
  input  logic          dsel_i,
  input  logic [CW-1:0] rst_dly_i,
  output logic          sw_en_o
);
  localparam logic [CW-1:0] ON_LIM    = CW'(T_ON);
  localparam logic [CW-1:0] PULSE_LIM = CW'(T_PULSE);
  localparam logic [CW-1:0] LONG_LIM  = CW'(T_OFF_LONG);
  localparam logic [CW-1:0] SHORT_LIM = CW'(T_OFF_SHORT);
  localparam logic [CW-1:0] QUAL_LIM  = CW'(OFF_QUAL);

  pk_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, key_cnt_q, key_cnt_d, qual_q, qual_d;
  logic          key_low_q, off_q, armed_q, armed_d, pend_q, pend_d, long_q, long_d;
  logic          key_fall, off_rise, off_ok;

  assign key_fall = key_low_i & ~key_low_q;
  assign off_rise = off_i & ~off_q;
  assign off_ok   = pend_q && (qual_q >= QUAL_LIM);

  // key hold time, saturating
  always_comb begin
    key_cnt_d = key_cnt_q;
    if (!key_low_i) key_cnt_d = '0;
    else if (tick_i && key_cnt_q != '1) key_cnt_d = key_cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    long_d  = long_q;
    armed_d = armed_q | ~key_low_i;
    cnt_d   = (tick_i && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
    // off request qualification, live only while on
    pend_d  = pend_q;
    qual_d  = qual_q;
    if (state_q != ST_ON || !off_i) begin
      pend_d = 1'b0;
      qual_d = '0;
    end else if (off_rise) begin
      pend_d = 1'b1;
      qual_d = '0;
    end else if (pend_q && tick_i && qual_q < QUAL_LIM) begin
      qual_d = qual_q + 1'b1;
    end

    case (state_q)
      ST_OFF: begin
        if (key_low_i && ((key_fall && !dsel_i) || key_cnt_q >= ON_LIM)) begin
          state_d = ST_ON;
          armed_d = 1'b0;
        end else if (wake_i) begin
          state_d = ST_ON;
        end
      end
      ST_ON: begin
        if (armed_q && key_low_i && ((key_fall && !dsel_i) || key_cnt_q >= rst_dly_i)) begin
          state_d = ST_PULSE;
          armed_d = 1'b0;
        end else if (off_ok) begin
          pend_d = 1'b0;
          if (!key_low_i && !wake_i) begin
            state_d = ST_OFF_WAIT;
            long_d  = dsel_i;
          end
        end
      end
      ST_OFF_WAIT: begin
        if (key_low_i || wake_i) state_d = ST_ON;
        else if (cnt_q >= (long_q ? LONG_LIM : SHORT_LIM)) state_d = ST_OFF;
      end
      default: begin
        if (cnt_q >= PULSE_LIM) state_d = ST_ON;
      end
    endcase

    if (state_d != state_q) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ON;
      cnt_q     <= '0;
      key_cnt_q <= '0;
      qual_q    <= '0;
      key_low_q <= 1'b0;
      off_q     <= 1'b0;
      armed_q   <= 1'b0;
      pend_q    <= 1'b0;
      long_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      key_cnt_q <= key_cnt_d;
      qual_q    <= qual_d;
      key_low_q <= key_low_i;
      off_q     <= off_i;
      armed_q   <= armed_d;
      pend_q    <= pend_d;
      long_q    <= long_d;
    end
  end

  assign sw_en_o = (state_q == ST_ON) || (state_q == ST_OFF_WAIT);

  // R2 / R7: the switch only closes from open on a key hold or wake
  a_r2_close_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && $past(state_q) == ST_OFF) |-> $past(key_low_i || wake_i));

  a_r3_reset_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE && $past(state_q) == ST_ON) |-> $past(armed_q));

  a_r4_pulse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && $past(state_q) == ST_PULSE) |-> ($past(cnt_q) >= PULSE_LIM));

  a_r8_open_via_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && $past(state_q) != ST_OFF) |-> ($past(state_q) == ST_OFF_WAIT));

  a_r10_wait_entry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF_WAIT && $past(state_q) == ST_ON) |-> $past(!key_low_i && !wake_i));
endmodule

// File: rtl/pwr_key_ctrl.sv
module pwr_key_ctrl #(
  parameter int T_ON_TICKS        = 2300,
  parameter int T_RST_TICKS       = 7500,
  parameter int T_PULSE_TICKS     = 400,
  parameter int T_OFF_LONG_TICKS  = 7300,
  parameter int T_OFF_SHORT_TICKS = 1,
  parameter int OFF_QUAL_TICKS    = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       key_ni,
  input  logic       wake_i,
  input  logic       off_i,
  input  logic       dsel_i,
  input  logic [2:0] mult_sel_i,
  output logic       sw_en_o,
  output logic       dis_en_o
);
  localparam int CW = $clog2(2 * T_RST_TICKS + T_ON_TICKS + T_OFF_LONG_TICKS
                             + T_PULSE_TICKS + OFF_QUAL_TICKS + 2) + 1;

  logic [3:0]    sync_q;
  logic [CW-1:0] rst_dly;
  logic          sw_en;

  // bit order: key, wake, off, strap; idle key and strap high
  pkc_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({key_ni, wake_i, off_i, dsel_i}),
    .q_o   (sync_q)
  );

  pkc_rst_delay #(.CW(CW), .BASE(T_RST_TICKS)) u_dly (
    .code_i(mult_sel_i),
    .dly_o (rst_dly)
  );

  pkc_fsm #(
    .CW(CW), .T_ON(T_ON_TICKS), .T_PULSE(T_PULSE_TICKS),
    .T_OFF_LONG(T_OFF_LONG_TICKS), .T_OFF_SHORT(T_OFF_SHORT_TICKS),
    .OFF_QUAL(OFF_QUAL_TICKS)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .key_low_i(~sync_q[3]),
    .wake_i   (sync_q[2]),
    .off_i    (sync_q[1]),
    .dsel_i   (sync_q[0]),
    .rst_dly_i(rst_dly),
    .sw_en_o  (sw_en)
  );

  assign sw_en_o  = sw_en;
  assign dis_en_o = ~sw_en;
endmodule

// File: tb/pwr_key_ctrl_tb_top.sv
module pwr_key_ctrl_tb_top;
  localparam int TON = 6, TRST = 8, TPUL = 5, TLONG = 7, TSHORT = 1, TQUAL = 2;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       key_n = 1'b1, wake = 1'b0, off = 1'b0, dsel = 1'b1;
  logic [2:0] mult = 3'd0;
  logic       sw_en, dis_en;
  int         checks = 0, errors = 0, div = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == 9) ? 0 : div + 1;
    tick <= (div == 9);
  end

  pwr_key_ctrl #(
    .T_ON_TICKS(TON), .T_RST_TICKS(TRST), .T_PULSE_TICKS(TPUL),
    .T_OFF_LONG_TICKS(TLONG), .T_OFF_SHORT_TICKS(TSHORT), .OFF_QUAL_TICKS(TQUAL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .key_ni(key_n), .wake_i(wake),
    .off_i(off), .dsel_i(dsel), .mult_sel_i(mult), .sw_en_o(sw_en), .dis_en_o(dis_en)
  );

  function automatic int exp_dly(input logic [2:0] code);
    case (code)
      3'd1: return TRST / 2;
      3'd2: return (TRST * 3) / 4;
      3'd3: return (TRST * 5) / 4;
      3'd4: return (TRST * 3) / 2;
      3'd5: return (TRST * 7) / 4;
      3'd6: return TRST * 2;
      default: return TRST;
    endcase
  endfunction

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // checks the switch and its complement (R11)
  task automatic chk(input logic exp, input string req);
    checks++;
    if (sw_en !== exp) begin
      errors++;
      $display("FAIL %s sw_en got %0b exp %0b", req, sw_en, exp);
    end
    checks++;
    if (dis_en !== ~exp) begin
      errors++;
      $display("FAIL R11 dis_en got %0b exp %0b", dis_en, ~exp);
    end
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(1'b1, "R1");
    wait_ticks(2);

    // R4: random short holds, no reset
    for (int i = 0; i < 4; i++) begin
      key_n = 1'b0;
      wait_ticks(($urandom % 5) + 1);
      key_n = 1'b1;
      wait_ticks(2);
      chk(1'b1, "R4 short hold");
    end

    // R4 full reset at default code, then R3 continued hold
    key_n = 1'b0;
    wait_ticks(TRST - 2); chk(1'b1, "R4 before delay");
    wait_ticks(4);        chk(1'b0, "R4 pulse");
    wait_ticks(TPUL + 1); chk(1'b1, "R4 restore");
    wait_ticks(12);       chk(1'b1, "R3 hold after reset");
    key_n = 1'b1;
    wait_ticks(2);

    // R5: multiplier codes, extremes then random
    for (int i = 0; i < 6; i++) begin
      logic [2:0] c;
      int d;
      c = (i == 0) ? 3'd1 : (i == 1) ? 3'd6 : 3'($urandom % 8);
      d = exp_dly(c);
      mult = c;
      wait_ticks(1);
      key_n = 1'b0;
      wait_ticks(d - 2); chk(1'b1, "R5 before scaled delay");
      wait_ticks(3);     chk(1'b0, "R5 after scaled delay");
      wait_ticks(2);     chk(1'b0, "R4 pulse held");
      wait_ticks(TPUL + 1); chk(1'b1, "R4 pulse end");
      key_n = 1'b1;
      wait_ticks(3);
    end
    mult = 3'd0;

    // R8 long turn-off
    off = 1'b1;
    wait_ticks(7); chk(1'b1, "R8 long delay running");
    wait_ticks(5); chk(1'b0, "R8 long turn-off");
    off = 1'b0;
    wait_ticks(1);

    // R2 key hold from open
    key_n = 1'b0; wait_ticks(3); key_n = 1'b1; wait_ticks(2);
    chk(1'b0, "R2 short hold");
    key_n = 1'b0;
    wait_ticks(TON - 2); chk(1'b0, "R2 before on time");
    wait_ticks(4);       chk(1'b1, "R2 on");
    wait_ticks(12);      chk(1'b1, "R3 hold after turn-on");
    key_n = 1'b1;
    wait_ticks(2);

    // R8 too-short off pulse ignored
    off = 1'b1; wait_ticks(1); off = 1'b0;
    wait_ticks(10); chk(1'b1, "R8 short pulse ignored");

    // R8 short delay with strap low
    dsel = 1'b0; wait_cyc(8);
    off = 1'b1;
    wait_ticks(1); chk(1'b1, "R8 before qualify");
    wait_ticks(5); chk(1'b0, "R8 short turn-off");
    off = 1'b0;
    wait_ticks(1);

    // R6 fast turn-on, then R3 hold
    key_n = 1'b0;
    wait_cyc(8);    chk(1'b1, "R6 fast on");
    wait_ticks(12); chk(1'b1, "R3 hold after fast on");
    key_n = 1'b1;
    wait_ticks(2);

    // R6 fast reset, full pulse
    key_n = 1'b0;
    wait_cyc(8);          chk(1'b0, "R6 fast reset");
    wait_ticks(TPUL - 2); chk(1'b0, "R6 pulse full length");
    wait_ticks(4);        chk(1'b1, "R6 pulse end");
    key_n = 1'b1;
    wait_ticks(2);

    // R7 wake from open
    off = 1'b1; wait_ticks(6); off = 1'b0;
    dsel = 1'b1; wait_ticks(1);
    chk(1'b0, "R7 open before wake");
    wake = 1'b1; wait_cyc(8); chk(1'b1, "R7 wake on");
    wake = 1'b0; wait_ticks(2);

    // R9 wake cancels turn-off
    off = 1'b1;
    wait_ticks(5); chk(1'b1, "R9 in delay");
    wake = 1'b1; wait_ticks(1); wake = 1'b0;
    wait_ticks(10); chk(1'b1, "R9 wake cancel");
    off = 1'b0; wait_ticks(1);

    // R9 key cancels turn-off
    off = 1'b1;
    wait_ticks(5);
    key_n = 1'b0; wait_ticks(1); key_n = 1'b1;
    wait_ticks(10); chk(1'b1, "R9 key cancel");
    off = 1'b0; wait_ticks(1);

    // R10 off qualifying under wake is dropped
    wake = 1'b1; wait_cyc(8);
    off = 1'b1;
    wait_ticks(12); chk(1'b1, "R10 dropped under wake");
    wake = 1'b0;
    wait_ticks(12); chk(1'b1, "R10 not served later");
    off = 1'b0;
    wait_ticks(1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule